// File: doc/BRIEF.md
# Saturating Split-Word Time Counter

This block keeps elapsed time as a 47-bit count that advances by one on each pulse of a slow tick enable, typically 32.768 kHz. At that rate 47 bits hold time from a 1970 epoch into early 2106, well past the 2038 overflow of 32-bit seconds. The count never wraps. Once every bit is one it stays there, and it raises a sticky violation flag. That flag drives a security-violation output and, when enabled, an interrupt.

Software reaches the counter through a small word-addressed register port. The low 32 bits of the count are one word and the upper 15 bits are a second word. Reading the low word copies the upper bits into a shadow register, and the next read of the high word returns that copy. Both halves therefore describe the same instant, even if a tick carries into the upper bits between the two reads.

The register port is a valid/ready request channel with a valid-only response. `req_ready` is tied high, so every request is taken on the edge where `req_valid` is high, and a requester never waits. A read answers with `rsp_valid` for exactly one cycle, one cycle after it was accepted. Writes give no response. The response path has no ready signal, so the requester must always be able to take a response.

Top module: `rtc_sat_top`

## Requirements
- R1: While the count-enable bit (control word, address 0, bit 0) is set, each cycle with `tick_en` high adds one to the 47-bit count, and a carry out of the low 32 bits reaches the upper 15 bits.
- R2: While the count-enable bit is clear, `tick_en` does not change the count.
- R3: The count never wraps. At all ones, further ticks leave it at all ones.
- R4: The cycle after the count is all ones, the violation flag (status word, address 1, bit 0) is set, and the `violation` output follows the flag.
- R5: The flag stays set until a one is written to status bit 0. Writing zero leaves it unchanged. If the count is still all ones when the flag is cleared, the flag sets again on the next cycle.
- R6: `irq` is high exactly when the violation flag and the interrupt-enable bit (control word bit 1) are both set.
- R7: A read of the low word (address 2) returns count bits 31..0 and saves count bits 46..32 into a shadow register. A read of the high word (address 3) returns the shadow, not the live upper bits.
- R8: A read of the high word returns zero in bits 31..15. A write to the high word loads count bits 46..32 from write-data bits 14..0.
- R9: Writes to the low or high word take effect only while the count-enable bit is clear. While it is set, they are ignored.
- R10: A synchronous reset clears the count, both control bits, the flag and the shadow. Afterwards, reading any word returns zero.
- R11: `req_ready` is always high. A read request produces `rsp_valid` for one cycle on the next cycle. A write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Time-base pulse, one cycle per count step |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Word select: 0 control, 1 status, 2 low count, 3 high count |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_data | output | 32 | Read data |
| violation | output | 1 | Security violation, the sticky flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, these rules:
- the count moves by exactly one per enabled tick;
- the count holds when it is idle and holds at all ones;
- the flag follows the saturated count;
- the interrupt is gated by its enable bit;
- a response follows every read and no other request;
- the high word has a zero upper part.

Only the bench scenarios can show the register-level behaviour:
- the shadow coherence of a low-then-high read pair across a carry;
- a count write being ignored while counting;
- the write-one-to-clear flag setting again while the count stays saturated, and clearing once a load moves the count off its maximum.

// File: rtl/rtc_sat_pkg.sv
package rtc_sat_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_LO   = 2'd2,
    SEL_HI   = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/rtc_sat_counter.sv
module rtc_sat_counter #(
  parameter int CNT_W  = 47,
  parameter int LO_W   = 32,
  localparam int HI_W  = CNT_W - LO_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             ld_lo,
  input  logic             ld_hi,
  input  logic [LO_W-1:0]  ld_data,
  output logic [CNT_W-1:0] value,
  output logic             at_max
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             step;

  assign at_max  = &cnt_q;
  assign step    = run && tick && !at_max;
  assign cnt_inc = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_inc;
    end else begin
      if (ld_lo) cnt_q[LO_W-1:0]     <= ld_data;
      if (ld_hi) cnt_q[CNT_W-1:LO_W] <= ld_data[HI_W-1:0];
    end
  end

  assign value = cnt_q;

endmodule

// File: rtl/rtc_sat_regs.sv
module rtc_sat_regs #(
  parameter int CNT_W  = 47,
  parameter int LO_W   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  localparam int HI_W  = CNT_W - LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        wr_bits,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              at_max,
  output logic              run,
  output logic              irq_en,
  output logic              flag,
  output logic              ld_lo,
  output logic              ld_hi,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  import rtc_sat_pkg::*;

  reg_sel_e          sel;
  logic              rd_fire, wr_fire, clr_req;
  logic              run_q, ien_q, flag_q;
  logic [HI_W-1:0]   shadow_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q, rd_mux;

  assign sel     = reg_sel_e'(req_addr);
  assign rd_fire = req_valid && !req_write;
  assign wr_fire = req_valid && req_write;
  assign clr_req = wr_fire && (sel == SEL_STAT) && wr_bits[0];
  assign ld_lo   = wr_fire && (sel == SEL_LO) && !run_q;
  assign ld_hi   = wr_fire && (sel == SEL_HI) && !run_q;

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CTRL: rd_mux[1:0]      = {ien_q, run_q};
      SEL_STAT: rd_mux[0]        = flag_q;
      SEL_LO:   rd_mux[LO_W-1:0] = cnt[LO_W-1:0];
      SEL_HI:   rd_mux[HI_W-1:0] = shadow_q;
      default:  rd_mux           = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q       <= 1'b0;
      ien_q       <= 1'b0;
      flag_q      <= 1'b0;
      shadow_q    <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      if (wr_fire && sel == SEL_CTRL) begin
        run_q <= wr_bits[0];
        ien_q <= wr_bits[1];
      end
      flag_q      <= at_max || (flag_q && !clr_req);
      rsp_valid_q <= rd_fire;
      if (rd_fire) begin
        rsp_data_q <= rd_mux;
        if (sel == SEL_LO) shadow_q <= cnt[CNT_W-1:LO_W];
      end
    end
  end

  assign run       = run_q;
  assign irq_en    = ien_q;
  assign flag      = flag_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/rtc_sat_top.sv
module rtc_sat_top #(
  parameter int CNT_W  = 47,
  parameter int LO_W   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              violation,
  output logic              irq
);

  logic [CNT_W-1:0] cnt_val;
  logic             at_max, run, irq_en, flag, ld_lo, ld_hi;

  assign req_ready = 1'b1;

  rtc_sat_counter #(.CNT_W(CNT_W), .LO_W(LO_W)) counter_i (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_en),
    .run     (run),
    .ld_lo   (ld_lo),
    .ld_hi   (ld_hi),
    .ld_data (req_wdata[LO_W-1:0]),
    .value   (cnt_val),
    .at_max  (at_max)
  );

  rtc_sat_regs #(.CNT_W(CNT_W), .LO_W(LO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .wr_bits   (req_wdata[1:0]),
    .cnt       (cnt_val),
    .at_max    (at_max),
    .run       (run),
    .irq_en    (irq_en),
    .flag      (flag),
    .ld_lo     (ld_lo),
    .ld_hi     (ld_hi),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  assign violation = flag;
  assign irq       = flag && irq_en;

endmodule

// File: rtl/rtc_sat_chk.sv
module rtc_sat_chk #(
  parameter int CNT_W  = 47,
  parameter int LO_W   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic [CNT_W-1:0]  cnt,
  input logic              run,
  input logic              irq_en,
  input logic              violation,
  input logic              irq
);
  localparam int HI_W = CNT_W - LO_W;

  logic cnt_wr, rd_hi;
  assign cnt_wr = req_valid && req_write && req_addr[1];
  assign rd_hi  = req_valid && !req_write && (req_addr == ADDR_W'(3));

  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    run && tick_en && !(&cnt) |=> cnt == $past(cnt) + {{(CNT_W-1){1'b0}}, 1'b1});

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !run && !cnt_wr |=> $stable(cnt));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (&cnt) && run |=> (&cnt));

  a_r4_flag_on_max: assert property (@(posedge clk) disable iff (rst)
    (&cnt) |=> violation);

  a_r6_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq |-> (violation && irq_en));

  a_r6_irq_when_both: assert property (@(posedge clk) disable iff (rst)
    (violation && irq_en) |-> irq);

  a_r11_rsp_follows_read: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_write |=> rsp_valid);

  a_r11_no_rsp: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rsp_valid);

  a_r8_hi_zero: assert property (@(posedge clk) disable iff (rst)
    rd_hi |=> rsp_data[DATA_W-1:HI_W] == '0);

endmodule

bind rtc_sat_top rtc_sat_chk #(.CNT_W(CNT_W), .LO_W(LO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .tick_en   (tick_en),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .cnt       (cnt_val),
  .run       (run),
  .irq_en    (irq_en),
  .violation (violation),
  .irq       (irq)
);

// File: tb/rtc_sat_top_tb_top.sv
module rtc_sat_top_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        tick_en;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        violation, irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  rtc_sat_top dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .violation(violation), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data as responses arrive
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R11 unexpected response", 32'h1, 32'h0);
      end else begin
        check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tick_en = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = 2'd0; req_wdata = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R10 reset state
    check("R10 violation after reset", {31'b0, violation}, 32'h0);
    check("R10 irq after reset", {31'b0, irq}, 32'h0);
    check("R11 ready high", {31'b0, req_ready}, 32'h1);
    rd(2'd0, 32'h0, "R10 ctrl reset");
    rd(2'd1, 32'h0, "R10 status reset");
    rd(2'd2, 32'h0, "R10 low reset");
    rd(2'd3, 32'h0, "R10 high reset");

    // R2: ticks ignored while disabled
    ticks(4);
    rd(2'd2, 32'h0, "R2 no count while disabled");

    // R1: count and carry
    wr(2'd2, 32'hFFFF_FFFE);
    wr(2'd3, 32'h0000_0003);
    wr(2'd0, 32'h1);
    ticks(3);
    wr(2'd0, 32'h0);
    rd(2'd2, 32'h0000_0001, "R1 low after carry");
    rd(2'd3, 32'h0000_0004, "R1 high after carry");

    // R8: upper bits of the high word
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd2, 32'h0000_0001, "R8 low untouched");
    rd(2'd3, 32'h0000_7FFF, "R8 high masked");

    // R9: writes ignored while counting
    wr(2'd2, 32'h0000_0010);
    wr(2'd3, 32'h0000_0002);
    wr(2'd0, 32'h1);
    wr(2'd2, 32'h1234_5678);
    wr(2'd3, 32'h0000_0055);
    wr(2'd0, 32'h0);
    rd(2'd2, 32'h0000_0010, "R9 low write ignored");
    rd(2'd3, 32'h0000_0002, "R9 high write ignored");

    // R7: shadow coherence across a carry
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'h0000_0007);
    wr(2'd0, 32'h1);
    rd(2'd2, 32'hFFFF_FFFF, "R7 low before carry");
    ticks(1);
    rd(2'd3, 32'h0000_0007, "R7 high from shadow");
    rd(2'd2, 32'h0000_0000, "R7 low after carry");
    rd(2'd3, 32'h0000_0008, "R7 high after new capture");
    wr(2'd0, 32'h0);

    // R3 / R4 / R6: saturation
    wr(2'd2, 32'hFFFF_FFFD);
    wr(2'd3, 32'h0000_7FFF);
    wr(2'd0, 32'h3);
    ticks(1);
    idle(2);
    check("R4 no flag below max", {31'b0, violation}, 32'h0);
    ticks(1);
    idle(1);
    check("R4 violation at max", {31'b0, violation}, 32'h1);
    check("R6 irq with enable", {31'b0, irq}, 32'h1);
    ticks(3);
    wr(2'd0, 32'h2);
    rd(2'd2, 32'hFFFF_FFFF, "R3 low saturated");
    rd(2'd3, 32'h0000_7FFF, "R3 high saturated");

    // R5: clear while saturated sets again
    wr(2'd1, 32'h1);
    idle(1);
    check("R5 reasserts while saturated", {31'b0, violation}, 32'h1);
    rd(2'd1, 32'h1, "R5 status still set");
    wr(2'd2, 32'h0);
    idle(1);
    check("R5 sticky after leaving max", {31'b0, violation}, 32'h1);
    wr(2'd1, 32'h0);
    idle(1);
    check("R5 write zero keeps flag", {31'b0, violation}, 32'h1);
    wr(2'd1, 32'h1);
    idle(1);
    check("R5 cleared by write one", {31'b0, violation}, 32'h0);
    check("R6 irq low after clear", {31'b0, irq}, 32'h0);

    // R6: interrupt gated by enable
    wr(2'd0, 32'h0);
    wr(2'd2, 32'hFFFF_FFFF);
    idle(2);
    check("R4 flag from loaded max", {31'b0, violation}, 32'h1);
    check("R6 irq masked", {31'b0, irq}, 32'h0);
    wr(2'd0, 32'h2);
    idle(1);
    check("R6 irq unmasked", {31'b0, irq}, 32'h1);
    rd(2'd0, 32'h2, "R11 ctrl readback");

    idle(4);
    check("R11 all responses seen", exp_q.size(), 32'h0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule